// File: doc/BRIEF.md
# Loadable Binary Up Counter with Asynchronous Clear

This block is a small synchronous binary up counter, four bits wide by default. Software never touches it. Surrounding logic drives it through three controls: an active-low clear, a load strobe and a count enable. It is used as a tick or event counter, or as a programmable divider that starts from a preset value.

At every rising clock edge the block applies exactly one of three actions, in a fixed priority order: load a parallel value, advance by one, or keep the current value. The clear input is outside that order. It acts at once, without waiting for an edge, and it overrides everything else for as long as it stays low.

A carry output goes high when the counter is about to roll over from all ones. It can drive the count enable of a second counter, so the two together form a wider counter with no extra logic.

Top module: `ldclr_counter`

## Requirements
- R1: While `clear_n` is low, `q` is zero. The clear takes effect without a clock edge and holds against any `load`, `count` or clock activity.
- R2: With `clear_n` high, a rising edge with `load` high puts `din` into `q`. This happens whatever the value of `count`.
- R3: With `clear_n` high and `load` low, a rising edge with `count` high makes `q` one greater.
- R4: With `clear_n` high and both `load` and `count` low, a rising edge leaves `q` unchanged.
- R5: `carry_o` is high exactly when `count` is 1, `load` is 0 and `q` is all ones (1111 at the default width). Otherwise it is 0.
- R6: Advancing from all ones gives all zeros (1111 to 0000). Every edge on which `carry_o` is high is followed by `q` equal to zero.
- R7: After `clear_n` returns high, the first rising edge with `count` high and `load` low moves `q` from 0 to 1.
- R8: Two instances form a counter twice as wide when the upper instance's `count` is driven by the lower instance's `carry_o` and both share the clock and clear. The pair then steps through consecutive binary values, including across the boundary between low and high halves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Asynchronous clear, active low |
| load | input | 1 | Parallel load strobe; highest synchronous priority |
| count | input | 1 | Count enable; applies when load is low |
| din | input | WIDTH | Parallel load value |
| q | output | WIDTH | Current counter value |
| carry_o | output | 1 | Rollover indication for cascading |

## Verification
The bound checker enforces several properties on every cycle while clear is released:
- A load edge always yields the previous cycle's `din`.
- A count edge yields the old value plus one.
- An idle edge leaves the value stable.
- A carry is followed by zero.
- A carry never appears without count high and load low.

It also checks at each falling clock edge that a low clear means a zero value.

Some behaviours only the directed scenarios can show:
- Clear acting between edges, before any clock edge arrives.
- Counting restarting on the first edge after release.
- Carry staying low when load or hold masks an all-ones value.
- Two chained instances carrying cleanly from the lower half into the upper half.

// File: rtl/ldclr_pkg.sv
package ldclr_pkg;

    // Action chosen for the next rising edge.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2
    } ldclr_act_e;

endpackage

// File: rtl/ldclr_select.sv
module ldclr_select
    import ldclr_pkg::*;
(
    input  logic       load,
    input  logic       count,
    output ldclr_act_e act
);

    // Fixed priority: load wins over count, and count wins over hold.
    always_comb begin
        if (load) begin
            act = ACT_LOAD;
        end else if (count) begin
            act = ACT_COUNT;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/ldclr_incr.sv
module ldclr_incr #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt,
    output logic             all_ones
);

    logic [WIDTH-1:0] tgl;

    // Bit i flips when every bit below it is set.
    // Bit 0 always flips.
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_tgl
            if (i == 0) begin : g_lsb
                assign tgl[i] = 1'b1;
            end else begin : g_upper
                assign tgl[i] = &cur[i-1:0];
            end
        end
    endgenerate

    assign nxt      = cur ^ tgl;
    assign all_ones = &cur;

endmodule

// File: rtl/ldclr_counter.sv
module ldclr_counter
    import ldclr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             load,
    input  logic             count,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             carry_o
);

    typedef struct packed {
        logic [WIDTH-1:0] val;
    } cnt_state_t;

    cnt_state_t       st_d;
    cnt_state_t       st_q;
    ldclr_act_e       act;
    logic [WIDTH-1:0] inc_val;
    logic             at_max;

    ldclr_select u_select (
        .load  (load),
        .count (count),
        .act   (act)
    );

    ldclr_incr #(
        .WIDTH (WIDTH)
    ) u_incr (
        .cur      (st_q.val),
        .nxt      (inc_val),
        .all_ones (at_max)
    );

    // Next-state computation.
    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_LOAD:  st_d.val = din;
            ACT_COUNT: st_d.val = inc_val;
            default:   st_d.val = st_q.val;
        endcase
    end

    // State register, cleared asynchronously.
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q       = st_q.val;
    assign carry_o = (act == ACT_COUNT) && at_max;

endmodule

// File: rtl/ldclr_counter_chk.sv
module ldclr_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clear_n,
    input logic             load,
    input logic             count,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] q,
    input logic             carry_o
);

    // R1: a low clear forces zero.
    always @(negedge clk) begin
        if (clear_n === 1'b0) begin
            p_clear_zero_r1: assert (q == '0)
                else $error("clear low with nonzero value");
        end
    end

    // R2: load takes din, regardless of count.
    p_load_din_r2: assert property (@(posedge clk) disable iff (!clear_n)
        load |=> q == $past(din));

    // R3: count advances the value by one.
    p_count_inc_r3: assert property (@(posedge clk) disable iff (!clear_n)
        (!load && count) |=> q == WIDTH'($past(q) + 1'b1));

    // R4: with no action, the value is held.
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!clear_n)
        (!load && !count) |=> $stable(q));

    // R5: carry needs count high and load low.
    p_carry_gate_r5: assert property (@(posedge clk) disable iff (!clear_n)
        carry_o |-> (count && !load));

    // R6: a carry edge is followed by zero.
    p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!clear_n)
        carry_o |=> q == '0);

endmodule

bind ldclr_counter ldclr_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .clear_n (clear_n),
    .load    (load),
    .count   (count),
    .din     (din),
    .q       (q),
    .carry_o (carry_o)
);

// File: tb/ldclr_counter_tb.sv
module ldclr_counter_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clear_n = 1'b1;
    logic         load = 1'b0;
    logic         count = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] din_hi = '0;
    logic [W-1:0] q;
    logic [W-1:0] q_hi;
    logic         carry_o;
    logic         carry_hi;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ldclr_counter #(.WIDTH(W)) u_dut (
        .clk     (clk),
        .clear_n (clear_n),
        .load    (load),
        .count   (count),
        .din     (din),
        .q       (q),
        .carry_o (carry_o)
    );

    // Upper half of the cascade, enabled by the lower half's carry.
    ldclr_counter #(.WIDTH(W)) u_hi (
        .clk     (clk),
        .clear_n (clear_n),
        .load    (load),
        .count   (carry_o),
        .din     (din_hi),
        .q       (q_hi),
        .carry_o (carry_hi)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one edge, then settle 5 ns past it.
    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic t_reset();
        #1 clear_n = 1'b0;
        #2;
        check("R1 reset value", int'(q), 0);
        check("R1 reset carry", int'(carry_o), 0);
        tick();
        check("R1 reset held over edge", int'(q), 0);
        clear_n = 1'b1;
    endtask

    task automatic t_load_priority();
        din = 4'hA;
        load = 1'b1;
        count = 1'b1;
        tick();
        check("R2 load over count", int'(q), 'hA);
        load = 1'b0;
        count = 1'b0;
    endtask

    task automatic t_count();
        count = 1'b1;
        tick();
        check("R3 count step1", int'(q), 'hB);
        tick();
        tick();
        check("R3 count step3", int'(q), 'hD);
        count = 1'b0;
    endtask

    task automatic t_hold();
        tick();
        check("R4 hold edge1", int'(q), 'hD);
        din = 4'h3;
        tick();
        check("R4 hold edge2", int'(q), 'hD);
    endtask

    task automatic t_carry_wrap();
        din = 4'hF;
        load = 1'b1;
        tick();
        check("R5 carry masked by load", int'(carry_o), 0);
        load = 1'b0;
        #1;
        check("R5 carry low on hold", int'(carry_o), 0);
        count = 1'b1;
        #1;
        check("R5 carry high at max", int'(carry_o), 1);
        load = 1'b1;
        #1;
        check("R5 carry low when load", int'(carry_o), 0);
        load = 1'b0;
        tick();
        check("R6 wrap to zero", int'(q), 0);
        check("R5 carry low after wrap", int'(carry_o), 0);
        count = 1'b0;
    endtask

    task automatic t_async_clear();
        din = 4'h9;
        load = 1'b1;
        tick();
        load = 1'b0;
        check("R2 load 9", int'(q), 'h9);
        clear_n = 1'b0;
        #2;
        check("R1 clear between edges", int'(q), 0);
        count = 1'b1;
        tick();
        check("R1 clear holds over count edge", int'(q), 0);
        clear_n = 1'b1;
        tick();
        check("R7 first edge after release", int'(q), 1);
        tick();
        check("R7 second edge after release", int'(q), 2);
        count = 1'b0;
    endtask

    task automatic t_cascade();
        din = 4'hE;
        din_hi = 4'h3;
        load = 1'b1;
        tick();
        load = 1'b0;
        check("R8 cascade load", int'({q_hi, q}), 'h3E);
        count = 1'b1;
        tick();
        check("R8 cascade 3F", int'({q_hi, q}), 'h3F);
        tick();
        check("R8 cascade cross 40", int'({q_hi, q}), 'h40);
        tick();
        check("R8 cascade 41", int'({q_hi, q}), 'h41);
        count = 1'b0;
    endtask

    initial begin
        t_reset();
        t_load_priority();
        t_count();
        t_hold();
        t_carry_wrap();
        t_async_clear();
        t_cascade();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule